// File: doc/BRIEF.md
# Cascaded Conversion Clock and Tick Divider

This block produces the timing strobes a slow analog-to-digital converter controller needs, all from a single fast parent clock. A main divider turns the parent clock into a conversion clock enable. Two further dividers count those conversion enables and produce a short tick, nominally 10 µs, and a long tick, nominally 1 ms. All three strobes are one parent cycle wide and are meant to be used as clock enables by logic that runs on the parent clock.

Software computes the divide ratios from the clock rates and writes them through a single 32-bit configuration write port. Each 8-bit field holds its ratio minus one. The two tick dividers are cascaded behind the main divider, so their fields count conversion-clock periods, not parent cycles. Any configuration write restarts every divider from zero in the same cycle. This keeps a ratio change from producing a shortened or doubled period.

Top module: `adc_tick_gen`

## Requirements
- R1: After reset all three fields are zero and all counters are cleared. Until the first write, `main_en`, `tick_10us` and `tick_1ms` are high in every cycle.
- R2: With main field M in `cfg_wdata[7:0]`, `main_en` pulses once every M+1 parent cycles. Counting the first cycle after the write edge as cycle 0, the pulses fall at cycles M, 2M+1, 3M+2, and so on.
- R3: With field T in `cfg_wdata[15:8]`, `tick_10us` is high on main pulse number j (0-based after the write) exactly when j mod (T+1) equals T.
- R4: With field S in `cfg_wdata[23:16]`, `tick_1ms` is high on main pulse number j exactly when j mod (S+1) equals S. It counts main pulses, not short ticks.
- R5: `tick_10us` and `tick_1ms` are high only in cycles where `main_en` is high.
- R6: A field value of zero means divide by one. The strobe is then high on every qualifying cycle: every parent cycle for the main divider, and every main pulse for the tick dividers.
- R7: In a cycle where `cfg_we` is high, all three outputs are low. The write reloads all counters to zero, so the new ratios apply from the next cycle.
- R8: Bits `cfg_wdata[31:24]` have no effect on any output.
- R9: Every strobe whose field is nonzero is exactly one parent cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: [7:0] main ratio-1, [15:8] short ratio-1, [23:16] long ratio-1 |
| main_en | output | 1 | Conversion clock enable |
| tick_10us | output | 1 | Short tick, aligned with a main enable |
| tick_1ms | output | 1 | Long tick, aligned with a main enable |

## Verification
Several properties are checked on every cycle:
- Each counter stays within its programmed ratio.
- A write clears every counter in the next cycle.
- No tick appears without a main enable.
- A strobe with a nonzero ratio never lasts two cycles.
- A zero main ratio gives a strobe on every cycle.

Exact phase and period can only be shown by the bench's scenarios. These include where each pulse falls after a write, that the long tick counts main pulses rather than short ticks, and that the top byte is ignored. The bench shows these by sweeping small ratio combinations and comparing every cycle against an arithmetic model.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;

  localparam int CFG_W    = 32;
  localparam int DIV_W    = 8;
  localparam int MAIN_LSB = 0;
  localparam int US_LSB   = 8;
  localparam int MS_LSB   = 16;
  localparam int USED_W   = MS_LSB + DIV_W;

  typedef struct packed {
    logic [DIV_W-1:0] ms_div;
    logic [DIV_W-1:0] us_div;
    logic [DIV_W-1:0] main_div;
  } tick_cfg_t;

  function automatic tick_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    tick_cfg_t c;
    c.main_div = w[MAIN_LSB +: DIV_W];
    c.us_div   = w[US_LSB   +: DIV_W];
    c.ms_div   = w[MS_LSB   +: DIV_W];
    return c;
  endfunction

endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import adc_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output tick_cfg_t        cfg
);

  logic unused_hi;
  assign unused_hi = ^wdata[CFG_W-1:USED_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= cfg_unpack(wdata);
  end

  p_held_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) && $past(rst_n) |-> $stable(cfg));

endmodule

// File: rtl/tick_div_stage.sv
module tick_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] div,
  output logic         hit
);

  logic [W-1:0] cnt;
  logic         at_end;

  function automatic logic [W-1:0] step(input logic [W-1:0] c,
                                        input logic [W-1:0] d);
    return (c == d) ? '0 : c + 1'b1;
  endfunction

  assign at_end = (cnt == div);
  assign hit    = adv && !clr && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= step(cnt, div);
  end

  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div);

  p_reload_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) && $past(rst_n) |-> cnt == '0);

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit && div != '0 |=> !hit);

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
  import adc_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             main_en,
  output logic             tick_10us,
  output logic             tick_1ms
);

  tick_cfg_t cfg;
  logic      main_hit;
  logic      us_hit;
  logic      ms_hit;

  tick_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  tick_div_stage #(.W(DIV_W)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .adv   (1'b1),
    .div   (cfg.main_div),
    .hit   (main_hit)
  );

  tick_div_stage #(.W(DIV_W)) u_us (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .adv   (main_hit),
    .div   (cfg.us_div),
    .hit   (us_hit)
  );

  tick_div_stage #(.W(DIV_W)) u_ms (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .adv   (main_hit),
    .div   (cfg.ms_div),
    .hit   (ms_hit)
  );

  assign main_en   = main_hit;
  assign tick_10us = us_hit;
  assign tick_1ms  = ms_hit;

  p_ticks_need_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_10us || tick_1ms) |-> main_en);

  p_zero_div_every_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.main_div == '0 && !cfg_we |-> main_en);

  p_restart_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) && $past(rst_n) && cfg.main_div != '0 |-> !main_en);

  p_quiet_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !(main_en || tick_10us || tick_1ms));

endmodule

// File: tb/sim_adc_tick_gen.sv
module sim_adc_tick_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        main_en, tick_10us, tick_1ms;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_tick_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .main_en   (main_en),
    .tick_10us (tick_10us),
    .tick_1ms  (tick_1ms)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int k);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, k, act, exp);
    end
  endtask

  // Arithmetic model: cycle k counted from the first cycle after a write (or reset)
  task automatic observe(input int m, input int t, input int s, input int k, input bit hi_tag);
    bit em, eu, es;
    int j;
    em = (k % (m + 1)) == m;
    j  = k / (m + 1);
    eu = em && ((j % (t + 1)) == t);
    es = em && ((j % (s + 1)) == s);
    if (hi_tag) begin
      chk("R8 main",  main_en,   em, k);
      chk("R8 short", tick_10us, eu, k);
      chk("R8 long",  tick_1ms,  es, k);
    end else begin
      chk((m == 0) ? "R6 main" : "R2 R9 main", main_en, em, k);
      chk((t == 0) ? "R6 short" : "R3 short", tick_10us, eu, k);
      chk((s == 0) ? "R6 long" : "R4 long", tick_1ms, es, k);
    end
    chk("R5", (tick_10us | tick_1ms) & ~main_en, 1'b0, k);
  endtask

  task automatic run_from(input int m, input int t, input int s, input int k0,
                          input int len, input bit hi_tag);
    for (int k = k0; k < len; k++) begin
      @(negedge clk);
      #1;
      observe(m, t, s, k, hi_tag);
    end
  endtask

  task automatic write_run(input int m, input int t, input int s, input int hi,
                           input int len, input bit hi_tag);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {hi[7:0], s[7:0], t[7:0], m[7:0]};
    #1;
    chk("R7 main",  main_en,   1'b0, -1);
    chk("R7 short", tick_10us, 1'b0, -1);
    chk("R7 long",  tick_1ms,  1'b0, -1);
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = 32'hDEAD_BEEF;
    #1;
    observe(m, t, s, 0, hi_tag);
    run_from(m, t, s, 1, len, hi_tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state, every strobe high every cycle
    chk("R1 main",  main_en,   1'b1, 0);
    chk("R1 short", tick_10us, 1'b1, 0);
    chk("R1 long",  tick_1ms,  1'b1, 0);
    run_from(0, 0, 0, 1, 6, 1'b0);

    // Sweep of small ratio combinations, restarting mid-pattern each time
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 3; t++)
        for (int si = 0; si < 3; si++) begin
          int s;
          int mx;
          s  = (si == 2) ? 3 : si;
          mx = (t > s) ? t : s;
          write_run(m, t, s, 0, 2 * (m + 1) * (mx + 1) + 3, 1'b0);
        end

    // Long tick counts main pulses, independent of the short tick
    write_run(9, 9, 9, 0, 210, 1'b0);
    write_run(15, 4, 20, 0, 2 * 16 * 21 + 3, 1'b0);
    write_run(2, 7, 0, 0, 60, 1'b0);

    // R8: upper byte ignored
    write_run(3, 1, 2, 8'h00, 40, 1'b1);
    write_run(3, 1, 2, 8'hFF, 40, 1'b1);
    write_run(3, 1, 2, 8'h5A, 40, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule